// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level translation structure kept in ordinary memory. The linear address is split into three fields. The top field selects an entry in a directory whose physical start comes from a base input. That entry names a page table, and the middle field selects an entry there. The table entry names a fixed-size page frame, and the low field is the byte offset inside the frame. Each entry is a 4-byte word, so one table holds at most 1024 entries in 4 KB.

A single request carries a linear address, a write flag and a user flag. The walker issues single-word reads and writes over a simple request/acknowledge memory port. It checks presence and privilege at both levels. It marks entries as accessed, and it marks the final entry as modified before a write is allowed to finish. It then ends with either a one-cycle completion pulse carrying the physical address, or a one-cycle fault pulse. On a fault it keeps the offending linear address in a dedicated register together with the fault cause.

Entry bit meanings: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 modified. Bits 31:12 hold the frame or table address.

Top module: `page_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req` are low and `fault_addr` is zero.
- R2: The directory entry is read from word address (`dir_base` with bits 11:0 forced to zero) + 4 × linear[31:22]; the low 12 base bits have no effect, and every memory address is word aligned.
- R3: A successful walk reads the table entry at (directory entry bits 31:12, low 12 bits zero) + 4 × linear[21:12]. It then pulses `done` for exactly one cycle with `paddr` = {table entry bits 31:12, linear[11:0]}, and `done` and `fault` are never high together.
- R4: A directory entry with bit 0 clear ends the walk with `fault` and `fault_kind` = 0 (not present), with no table access.
- R5: A table entry with bit 0 clear ends the walk with `fault` and `fault_kind` = 0.
- R6: A user request (`req_user` = 1) through an entry, at either level, whose bit 2 is clear faults with `fault_kind` = 1 (protection). Supervisor requests ignore bit 2.
- R7: A user write through an entry, at either level, whose bit 1 is clear faults with `fault_kind` = 1. Supervisor writes and user reads ignore bit 1.
- R8: On every fault, `fault_addr` takes the faulting linear address. It holds that value through later successful walks until the next fault.
- R9: Every directory entry that passes its checks, and every table entry of a successful walk, gets bit 5 set in memory. The write-back is skipped when the entry needs no change, so a walk whose entries already carry every needed bit makes no memory write.
- R10: For a write request, the table entry holds bit 6 set in memory before `done` rises. A directory entry write-back changes only bit 5, never bit 6.
- R11: `busy` is high from the cycle after a request is accepted until the walk ends, and requests arriving while busy are ignored. `mem_req` is held with a stable address and write flag until `mem_ack`, and is low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Physical start of the directory (bits 11:0 ignored) |
| req_valid | input | 1 | Translation request, taken when idle |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write access |
| req_user | input | 1 | Request comes from user privilege |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: translation failed |
| fault_kind | output | 1 | Cause of the latest fault: 0 not present, 1 protection |
| paddr | output | 32 | Physical address, valid while `done` is high |
| fault_addr | output | 32 | Linear address of the latest fault |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Word-aligned physical address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value read, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the current access |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high, that it holds it for one cycle per access, and that `mem_rdata` is valid in that cycle. The bench memory model answers each request one cycle later, drops the acknowledge for a cycle, and commits writes on the acknowledging edge. Requests are driven between clock edges. The bench injects extra requests only while a walk is in progress, which exercises the ignore path without breaking the handshake.

// File: rtl/page_walker_pkg.sv
package page_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_PDE, ST_UPDATE_PDE, ST_READ_PTE, ST_UPDATE_PTE, ST_DONE, ST_FAULT
  } walk_state_t;

  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;

  localparam logic KIND_ABSENT = 1'b0;
  localparam logic KIND_PROT   = 1'b1;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] laddr,
  input  logic [AW-1:0] pde,
  input  logic [AW-1:0] pte,
  output logic [AW-1:0] pde_addr,
  output logic [AW-1:0] pte_addr,
  output logic [AW-1:0] phys
);
  localparam logic [AW-1:0] FRAME_MASK = ~((AW'(1) << OFF_W) - AW'(1));
  localparam logic [AW-1:0] IDX_MASK   = (AW'(1) << IDX_W) - AW'(1);

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] tbl, input logic [AW-1:0] idx);
    return (tbl & FRAME_MASK) + (idx << 2);
  endfunction

  function automatic logic [AW-1:0] join_frame(input logic [AW-1:0] entry, input logic [AW-1:0] la);
    return (entry & FRAME_MASK) | (la & ~FRAME_MASK);
  endfunction

  assign pde_addr = slot_addr(base, laddr >> (OFF_W + IDX_W));
  assign pte_addr = slot_addr(pde, (laddr >> OFF_W) & IDX_MASK);
  assign phys     = join_frame(pte, laddr);
endmodule

// File: rtl/pw_perm_check.sv
module pw_perm_check (
  input  logic [2:0] flags,
  input  logic       user,
  input  logic       write,
  output logic       present,
  output logic       allowed
);
  import page_walker_pkg::*;
  assign present = flags[BIT_P];
  assign allowed = !(user && !flags[BIT_US]) && !(user && write && !flags[BIT_RW]);
endmodule

// File: rtl/page_walker.sv
module page_walker #(
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dir_base,
  input  logic          req_valid,
  input  logic [AW-1:0] req_laddr,
  input  logic          req_write,
  input  logic          req_user,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic          fault_kind,
  output logic [AW-1:0] paddr,
  output logic [AW-1:0] fault_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_ack
);
  import page_walker_pkg::*;

  localparam logic [AW-1:0] A_MASK = AW'(1) << BIT_A;
  localparam logic [AW-1:0] D_MASK = AW'(1) << BIT_D;

  walk_state_t   state;
  logic [AW-1:0] laddr_q, pde_q, pte_q;
  logic          wr_q, usr_q;
  logic [AW-1:0] pde_addr, pte_addr, phys;
  logic          ent_present, ent_allowed;
  logic [AW-1:0] pte_next;

  // named events for the checker
  logic walk_accept, pde_rd_evt, pte_rd_evt, pde_wr_evt, pte_wr_evt;
  assign walk_accept = (state == ST_IDLE) && req_valid;
  assign pde_rd_evt  = (state == ST_READ_PDE) && mem_ack;
  assign pte_rd_evt  = (state == ST_READ_PTE) && mem_ack;
  assign pde_wr_evt  = (state == ST_UPDATE_PDE) && mem_ack;
  assign pte_wr_evt  = (state == ST_UPDATE_PTE) && mem_ack;

  pw_addr_gen #(.AW(AW), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .base(dir_base), .laddr(laddr_q), .pde(pde_q), .pte(pte_q),
    .pde_addr(pde_addr), .pte_addr(pte_addr), .phys(phys)
  );

  pw_perm_check u_perm (
    .flags(mem_rdata[2:0]), .user(usr_q), .write(wr_q),
    .present(ent_present), .allowed(ent_allowed)
  );

  assign pte_next = mem_rdata | A_MASK | (wr_q ? D_MASK : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      laddr_q    <= '0;
      pde_q      <= '0;
      pte_q      <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      fault_addr <= '0;
      fault_kind <= KIND_ABSENT;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          laddr_q <= req_laddr;
          wr_q    <= req_write;
          usr_q   <= req_user;
          state   <= ST_READ_PDE;
        end
        ST_READ_PDE: if (mem_ack) begin
          pde_q <= mem_rdata | A_MASK;
          if (!ent_present) begin
            fault_kind <= KIND_ABSENT;
            fault_addr <= laddr_q;
            state      <= ST_FAULT;
          end else if (!ent_allowed) begin
            fault_kind <= KIND_PROT;
            fault_addr <= laddr_q;
            state      <= ST_FAULT;
          end else if (!mem_rdata[BIT_A]) begin
            state <= ST_UPDATE_PDE;
          end else begin
            state <= ST_READ_PTE;
          end
        end
        ST_UPDATE_PDE: if (mem_ack) state <= ST_READ_PTE;
        ST_READ_PTE: if (mem_ack) begin
          pte_q <= pte_next;
          if (!ent_present) begin
            fault_kind <= KIND_ABSENT;
            fault_addr <= laddr_q;
            state      <= ST_FAULT;
          end else if (!ent_allowed) begin
            fault_kind <= KIND_PROT;
            fault_addr <= laddr_q;
            state      <= ST_FAULT;
          end else if (pte_next != mem_rdata) begin
            state <= ST_UPDATE_PTE;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_UPDATE_PTE: if (mem_ack) state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        ST_FAULT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pte_addr;
    mem_wdata = pte_q;
    case (state)
      ST_READ_PDE:   begin mem_req = 1'b1; mem_addr = pde_addr; end
      ST_UPDATE_PDE: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = pde_addr; mem_wdata = pde_q; end
      ST_READ_PTE:   mem_req = 1'b1;
      ST_UPDATE_PTE: begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end

  assign busy  = (state != ST_IDLE);
  assign done  = (state == ST_DONE);
  assign fault = (state == ST_FAULT);
  assign paddr = phys;
endmodule

// File: rtl/page_walker_sva.sv
module page_walker_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic [AW-1:0] fault_addr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic [AW-1:0] mem_rdata,
  input logic          mem_ack,
  input logic [AW-1:0] laddr_q,
  input logic          wr_q,
  input logic          walk_accept,
  input logic          pde_rd_evt,
  input logic          pte_rd_evt,
  input logic          pde_wr_evt,
  input logic          pte_wr_evt
);
  import page_walker_pkg::*;

  logic [AW-1:0] pde_seen;
  logic          dirty_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pde_seen   <= '0;
      dirty_seen <= 1'b0;
    end else begin
      if (walk_accept) dirty_seen <= 1'b0;
      if (pde_rd_evt)  pde_seen   <= mem_rdata;
      if (pte_rd_evt)  dirty_seen <= mem_rdata[BIT_D];
      if (pte_wr_evt && mem_wdata[BIT_D]) dirty_seen <= 1'b1;
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R11
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R3
  AST_ABSENT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    pde_rd_evt && !mem_rdata[BIT_P] |=> fault); // R4
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_addr == laddr_q); // R8
  AST_DIR_ONLY_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    pde_wr_evt |-> mem_wdata == (pde_seen | (AW'(1) << BIT_A))); // R10
  AST_DIRTY_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done && wr_q |-> dirty_seen); // R10
endmodule

bind page_walker page_walker_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
  .fault_addr(fault_addr), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
  .mem_ack(mem_ack), .laddr_q(laddr_q), .wr_q(wr_q),
  .walk_accept(walk_accept), .pde_rd_evt(pde_rd_evt), .pte_rd_evt(pte_rd_evt),
  .pde_wr_evt(pde_wr_evt), .pte_wr_evt(pte_wr_evt)
);

// File: tb/page_walker_bench.sv
module page_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dir_base = 32'h0001_0ABC;
  logic        req_valid = 1'b0;
  logic [31:0] req_laddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        busy, done, fault, fault_kind, mem_req, mem_we;
  logic [31:0] paddr, fault_addr, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #5 clk = ~clk;

  page_walker u_page_walker (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base), .req_valid(req_valid),
    .req_laddr(req_laddr), .req_write(req_write), .req_user(req_user),
    .busy(busy), .done(done), .fault(fault), .fault_kind(fault_kind),
    .paddr(paddr), .fault_addr(fault_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem [bit [31:0]];
  int wr_count = 0;

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= peek(mem_addr);
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_count++;
      end
    end else mem_ack <= 1'b0;
  end

  typedef struct {
    bit          is_fault;
    bit          kind;
    logic [31:0] pa;
    logic [31:0] la;
    bit          wr;
    logic [31:0] pte_at;
    string       tag;
  } exp_t;

  exp_t sb[$];

  // independent model of a walk, from the requirements
  function automatic void predict(input logic [31:0] la, input bit wr, input bit us,
                                  output exp_t e, output int nwr,
                                  output logic [31:0] d_at, output logic [31:0] d_new,
                                  output logic [31:0] t_at, output logic [31:0] t_new);
    logic [31:0] d, t;
    nwr = 0;
    e.is_fault = 1'b0; e.kind = 1'b0; e.pa = '0; e.la = la; e.wr = wr;
    d_at = {dir_base[31:12], 12'h000} + {20'h0, la[31:22], 2'b00};
    d = peek(d_at); d_new = d;
    t_at = '0; t = '0; t_new = '0;
    if (d[0] == 1'b0) begin e.is_fault = 1'b1; e.kind = 1'b0; end
    else if ((us && !d[2]) || (us && wr && !d[1])) begin e.is_fault = 1'b1; e.kind = 1'b1; end
    else begin
      d_new = d | 32'h20;
      if (d_new != d) nwr++;
      t_at = {d[31:12], 12'h000} + {20'h0, la[21:12], 2'b00};
      t = peek(t_at); t_new = t;
      if (t[0] == 1'b0) begin e.is_fault = 1'b1; e.kind = 1'b0; end
      else if ((us && !t[2]) || (us && wr && !t[1])) begin e.is_fault = 1'b1; e.kind = 1'b1; end
      else begin
        t_new = t | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (t_new != t) nwr++;
        e.pa = {t[31:12], la[11:0]};
      end
    end
    e.pte_at = t_at;
  endfunction

  logic [31:0] last_fault_la = '0;

  // monitor: pop and compare each outcome
  always @(negedge clk) begin
    if (rst_n && (done || fault)) begin
      if (sb.size() == 0) check(1'b0, "R11 unexpected outcome", {30'h0, done, fault}, 32'h0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(fault == e.is_fault, {e.tag, " outcome"}, {31'h0, fault}, {31'h0, e.is_fault});
        if (e.is_fault) begin
          check(fault_kind == e.kind, {e.tag, " fault_kind"}, {31'h0, fault_kind}, {31'h0, e.kind});
          check(fault_addr == e.la, {e.tag, " R8 fault_addr"}, fault_addr, e.la);
          last_fault_la = e.la;
        end else begin
          check(paddr == e.pa, {e.tag, " R3 paddr"}, paddr, e.pa);
          check(fault_addr == last_fault_la, {e.tag, " R8 fault_addr held"}, fault_addr, last_fault_la);
          if (e.wr) check(peek(e.pte_at)[6] == 1'b1, {e.tag, " R10 dirty before done"}, peek(e.pte_at), 32'h40);
        end
      end
    end
  end

  task automatic walk(input logic [31:0] la, input bit wr, input bit us, input string tag, input bit poke);
    exp_t e; int nwr; logic [31:0] d_at, d_new, t_at, t_new;
    predict(la, wr, us, e, nwr, d_at, d_new, t_at, t_new);
    e.tag = tag;
    sb.push_back(e);
    wr_count = 0;
    @(negedge clk);
    req_valid = 1'b1; req_laddr = la; req_write = wr; req_user = us;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, {tag, " R11 busy"}, {31'h0, busy}, 32'h1);
    if (poke) begin
      req_valid = 1'b1; req_laddr = 32'h0080_0000; req_write = 1'b0; req_user = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
    end
    for (int i = 0; i < 200; i++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    check(done || fault, {tag, " walk finished"}, {30'h0, done, fault}, 32'h1);
    @(negedge clk);
    check(wr_count == nwr, {tag, " R9 write count"}, wr_count, nwr);
    check(peek(d_at) == d_new, {tag, " R9 directory entry"}, peek(d_at), d_new);
    if (t_at != 0) check(peek(t_at) == t_new, {tag, " R9 table entry"}, peek(t_at), t_new);
  endtask

  function automatic logic [31:0] la_of(input int di, input int ti, input int off);
    return (32'(di) << 22) | (32'(ti) << 12) | 32'(off);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // directory at 0x10000
    mem[32'h0001_0004] = 32'h0002_0007; // table at 0x20000, user rw, not accessed
    mem[32'h0001_0008] = 32'h0003_0006; // not present
    mem[32'h0001_000C] = 32'h0004_0023; // supervisor only, accessed
    mem[32'h0001_0010] = 32'h0005_0025; // user read-only, accessed
    mem[32'h0002_0000] = 32'hAAAA_A007;
    mem[32'h0002_0004] = 32'hF000_0006; // not present
    mem[32'h0002_0008] = 32'hBBBB_B005; // user read-only
    mem[32'h0002_000C] = 32'hCCCC_C003; // supervisor only
    mem[32'h0002_0010] = 32'hDDDD_D067; // already accessed and dirty
    mem[32'h0004_0000] = 32'hEEEE_E007;
    mem[32'h0005_0000] = 32'h1234_5007;

    repeat (3) @(negedge clk);
    check(!busy && !done && !fault && !mem_req, "R1 reset outputs", {28'h0, busy, done, fault, mem_req}, 32'h0);
    check(fault_addr == 32'h0, "R1 fault_addr reset", fault_addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    walk(la_of(1, 0, 12'h123), 1'b0, 1'b1, "R2 R3 R9 user read, base low bits ignored", 1'b0);
    walk(la_of(1, 0, 12'h456), 1'b1, 1'b1, "R10 user write sets dirty", 1'b0);
    walk(la_of(1, 0, 12'h789), 1'b1, 1'b1, "R9 no write-back needed", 1'b0);
    walk(la_of(2, 5, 12'h010), 1'b0, 1'b0, "R4 directory not present", 1'b0);
    walk(la_of(1, 1, 12'h020), 1'b0, 1'b0, "R5 table not present", 1'b0);
    walk(la_of(3, 0, 12'h030), 1'b0, 1'b1, "R6 user via supervisor directory", 1'b0);
    walk(la_of(3, 0, 12'h040), 1'b0, 1'b0, "R6 supervisor ignores user bit", 1'b0);
    walk(la_of(1, 2, 12'h050), 1'b1, 1'b1, "R7 user write read-only table", 1'b0);
    walk(la_of(1, 2, 12'h060), 1'b0, 1'b1, "R7 user read read-only table", 1'b0);
    walk(la_of(1, 2, 12'h070), 1'b1, 1'b0, "R7 supervisor write read-only", 1'b0);
    walk(la_of(4, 0, 12'h080), 1'b1, 1'b1, "R7 user write read-only directory", 1'b0);
    walk(la_of(1, 3, 12'h090), 1'b0, 1'b1, "R6 user via supervisor table", 1'b0);
    walk(la_of(1, 4, 12'hFFF), 1'b1, 1'b1, "R9 R10 entry already complete", 1'b0);
    walk(la_of(4, 0, 12'hABC), 1'b0, 1'b1, "R11 request while busy ignored", 1'b1);

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!busy && !mem_req, "R11 stays idle after ignored request", {30'h0, busy, mem_req}, 32'h0);
    end
    check(sb.size() == 0, "R11 scoreboard drained", sb.size(), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule